// File: doc/BRIEF.md
# Condition Suffix and Branch Evaluator

This combinational block sits in the decode/execute path of a small 32-bit RISC core. It looks at the four status flags (carry, sign, overflow and zero) and at the instruction in flight. From these it decides two things: whether a predicated instruction is allowed to commit, and whether a jump is taken.

ALU instructions and the other suffixed instructions carry a 4-bit condition code. This covers moves, loads, stores, the wide immediate moves, core index and interrupt. For these, the code picks one of sixteen conditions, and the result gates execution. Jumps take their condition from the 5-bit opcode instead. Jumps and the move-from-flags instruction always execute, and the suffix input has no effect on them.

Internally, a control module turns the instruction fields into a small strobe struct. The strobe selects a flag term, an inversion, and whether predication or branching applies. A datapath module builds the flag terms and combines them under that strobe.

Top module: `condEval`

## Requirements
- R1: With a predicated instruction, suffix 0000 enables execution when zero (flags bit 0) is 1, and suffix 0001 enables it when zero is 0.
- R2: Suffix 0110 follows carry (flags bit 3) and 0111 its inverse. Suffix 1000 follows sign (flags bit 2) and 1001 its inverse. Suffix 1100 follows overflow (flags bit 1) and 1101 its inverse.
- R3: The signed suffixes work as follows. 0100 enables when sign equals overflow. 0011 enables when they differ. 0010 enables when zero is 0 and sign equals overflow. 0101 enables when zero is 1 or sign differs from overflow.
- R4: Suffix 1110 enables when carry is 1 and zero is 0. Suffix 1111 enables when carry is 0 or zero is 1.
- R5: Suffix 1010 always enables execution, and suffix 1011 never does.
- R6: With isAlu=0, the jump opcodes are decided as follows. 01001 is taken when zero=1, and 01010 when zero=0. 01011 is taken when zero=0 and overflow equals sign. 01100 is taken when overflow equals sign. 01101 is taken when they differ. 01110 is taken when zero=1 and they differ. 01111 is always taken.
- R7: With isAlu=0, opcodes 01000 (move from flags) and 01001 to 01111 (jumps) always drive execEnable=1, whatever the suffix.
- R8: branchTaken is 0 whenever isAlu=1 or the opcode is outside 01001 to 01111.
- R9: With isAlu=0, any opcode other than 01000 to 01111 is predicated by the suffix exactly as an ALU instruction is. The opcode field is ignored when isAlu=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| isAlu | input | 1 | 1 for the ALU instruction format |
| opcode | input | 5 | Non-ALU opcode field |
| suffix | input | 4 | Assembled condition suffix code |
| flags | input | 4 | {carry, sign, overflow, zero} |
| execEnable | output | 1 | Instruction may commit |
| branchTaken | output | 1 | Jump is taken |

## Verification
The ALU format is driven with all sixteen suffixes across all sixteen flag combinations. This separates each condition from its inverse and from neighbouring signed and unsigned conditions. Every 5-bit non-ALU opcode is then swept over all flags with suffixes 0000, 1010, 1011 and 1111. This shows that jumps and move-from-flags ignore the suffix, that only the jump range raises branchTaken, and that the remaining opcodes are predicated the same way ALU instructions are.

// File: rtl/condEvalPkg.sv
package condEvalPkg;
  localparam int SUFFIX_W = 4;
  localparam int OPC_W    = 5;
  localparam int FLAG_W   = 4;
  localparam int TERM_W   = 4;
  localparam int NUM_TERM_SLOTS = 2 ** TERM_W;

  localparam int FLAG_C = 3;
  localparam int FLAG_S = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 0;

  localparam logic [OPC_W-1:0] OPC_MOVF    = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_JMP_LO  = 5'b01001;
  localparam logic [OPC_W-1:0] OPC_JMP_HI  = 5'b01111;

  typedef enum logic [TERM_W-1:0] {
    TERM_ZERO  = 4'd0,
    TERM_CARRY = 4'd1,
    TERM_SIGN  = 4'd2,
    TERM_OVF   = 4'd3,
    TERM_SGE   = 4'd4,
    TERM_SGT   = 4'd5,
    TERM_SLE   = 4'd6,
    TERM_HI    = 4'd7,
    TERM_ZLT   = 4'd8,
    TERM_TRUE  = 4'd9
  } condTerm_e;

  typedef struct packed {
    condTerm_e termSel;
    logic      invert;
    logic      usePredicate;
    logic      isBranch;
  } condStrobes_t;
endpackage

// File: rtl/condEvalCtrl.sv
module condEvalCtrl
  import condEvalPkg::*;
(
  input  logic                isAlu,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [SUFFIX_W-1:0] suffix,
  output condStrobes_t        strobes
);
  condTerm_e sufTerm;
  logic      sufInvert;
  condTerm_e jmpTerm;
  logic      jmpInvert;
  logic      inJumpRange;

  // Suffix code to flag term; odd codes in each pair usually invert.
  always_comb begin
    sufTerm   = TERM_TRUE;
    sufInvert = 1'b0;
    unique case (suffix)
      4'b0000: begin sufTerm = TERM_ZERO;  sufInvert = 1'b0; end
      4'b0001: begin sufTerm = TERM_ZERO;  sufInvert = 1'b1; end
      4'b0010: begin sufTerm = TERM_SGT;   sufInvert = 1'b0; end
      4'b0011: begin sufTerm = TERM_SGE;   sufInvert = 1'b1; end
      4'b0100: begin sufTerm = TERM_SGE;   sufInvert = 1'b0; end
      4'b0101: begin sufTerm = TERM_SLE;   sufInvert = 1'b0; end
      4'b0110: begin sufTerm = TERM_CARRY; sufInvert = 1'b0; end
      4'b0111: begin sufTerm = TERM_CARRY; sufInvert = 1'b1; end
      4'b1000: begin sufTerm = TERM_SIGN;  sufInvert = 1'b0; end
      4'b1001: begin sufTerm = TERM_SIGN;  sufInvert = 1'b1; end
      4'b1010: begin sufTerm = TERM_TRUE;  sufInvert = 1'b0; end
      4'b1011: begin sufTerm = TERM_TRUE;  sufInvert = 1'b1; end
      4'b1100: begin sufTerm = TERM_OVF;   sufInvert = 1'b0; end
      4'b1101: begin sufTerm = TERM_OVF;   sufInvert = 1'b1; end
      4'b1110: begin sufTerm = TERM_HI;    sufInvert = 1'b0; end
      4'b1111: begin sufTerm = TERM_HI;    sufInvert = 1'b1; end
      default: begin sufTerm = TERM_TRUE;  sufInvert = 1'b0; end
    endcase
  end

  // Jump opcode to flag term.
  always_comb begin
    jmpTerm   = TERM_TRUE;
    jmpInvert = 1'b1;
    case (opcode)
      5'b01001: begin jmpTerm = TERM_ZERO; jmpInvert = 1'b0; end
      5'b01010: begin jmpTerm = TERM_ZERO; jmpInvert = 1'b1; end
      5'b01011: begin jmpTerm = TERM_SGT;  jmpInvert = 1'b0; end
      5'b01100: begin jmpTerm = TERM_SGE;  jmpInvert = 1'b0; end
      5'b01101: begin jmpTerm = TERM_SGE;  jmpInvert = 1'b1; end
      5'b01110: begin jmpTerm = TERM_ZLT;  jmpInvert = 1'b0; end
      5'b01111: begin jmpTerm = TERM_TRUE; jmpInvert = 1'b0; end
      default:  begin jmpTerm = TERM_TRUE; jmpInvert = 1'b1; end
    endcase
  end

  assign inJumpRange = (opcode >= OPC_JMP_LO) && (opcode <= OPC_JMP_HI);

  always_comb begin
    strobes = '{termSel: sufTerm, invert: sufInvert, usePredicate: 1'b1, isBranch: 1'b0};
    if (!isAlu) begin
      if (inJumpRange) begin
        strobes = '{termSel: jmpTerm, invert: jmpInvert, usePredicate: 1'b0, isBranch: 1'b1};
      end else if (opcode == OPC_MOVF) begin
        strobes = '{termSel: TERM_TRUE, invert: 1'b0, usePredicate: 1'b0, isBranch: 1'b0};
      end
    end
  end

  always_comb begin
    if (isAlu) assert_alu_no_branch_R8: assert (!strobes.isBranch);
    if (!isAlu && inJumpRange) assert_jump_unpredicated_R7: assert (!strobes.usePredicate);
  end
endmodule

// File: rtl/condEvalData.sv
module condEvalData
  import condEvalPkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  condStrobes_t      strobes,
  output logic              execEnable,
  output logic              branchTaken
);
  logic [NUM_TERM_SLOTS-1:0] terms;
  logic cFlag, sFlag, vFlag, zFlag;
  logic signMatch;
  logic condHit;

  assign cFlag = flags[FLAG_C];
  assign sFlag = flags[FLAG_S];
  assign vFlag = flags[FLAG_V];
  assign zFlag = flags[FLAG_Z];
  assign signMatch = (sFlag == vFlag);

  always_comb begin
    terms = '0;
    terms[TERM_ZERO]  = zFlag;
    terms[TERM_CARRY] = cFlag;
    terms[TERM_SIGN]  = sFlag;
    terms[TERM_OVF]   = vFlag;
    terms[TERM_SGE]   = signMatch;
    terms[TERM_SGT]   = !zFlag && signMatch;
    terms[TERM_SLE]   = zFlag || !signMatch;
    terms[TERM_HI]    = cFlag && !zFlag;
    terms[TERM_ZLT]   = zFlag && !signMatch;
    terms[TERM_TRUE]  = 1'b1;
  end

  assign condHit     = terms[strobes.termSel] ^ strobes.invert;
  assign execEnable  = strobes.usePredicate ? condHit : 1'b1;
  assign branchTaken = strobes.isBranch & condHit;

  always_comb begin
    if (!strobes.isBranch) assert_branch_needs_jump_R8: assert (!branchTaken);
    if (!strobes.usePredicate) assert_unpredicated_runs_R7: assert (execEnable);
  end
endmodule

// File: rtl/condEval.sv
module condEval
  import condEvalPkg::*;
(
  input  logic                isAlu,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [SUFFIX_W-1:0] suffix,
  input  logic [FLAG_W-1:0]   flags,
  output logic                execEnable,
  output logic                branchTaken
);
  condStrobes_t strobes;

  condEvalCtrl u_ctrl (
    .isAlu   (isAlu),
    .opcode  (opcode),
    .suffix  (suffix),
    .strobes (strobes)
  );

  condEvalData u_data (
    .flags       (flags),
    .strobes     (strobes),
    .execEnable  (execEnable),
    .branchTaken (branchTaken)
  );

  always_comb begin
    if (isAlu && suffix == 4'b1010) assert_always_runs_R5: assert (execEnable);
    if (isAlu && suffix == 4'b1011) assert_never_runs_R5: assert (!execEnable);
    if (isAlu && suffix == 4'b0000) assert_eq_follows_zero_R1: assert (execEnable == flags[FLAG_Z]);
    if (!isAlu && opcode == 5'b01111) assert_jmp_taken_R6: assert (branchTaken);
  end
endmodule

// File: tb/condEval_tb.sv
`timescale 1ns/1ps
module condEval_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       isAlu;
  logic [4:0] opcode;
  logic [3:0] suffix;
  logic [3:0] flags;
  logic       execEnable;
  logic       branchTaken;

  condEval u_dut (
    .isAlu(isAlu), .opcode(opcode), .suffix(suffix), .flags(flags),
    .execEnable(execEnable), .branchTaken(branchTaken)
  );

  typedef struct {
    logic  expExec;
    logic  expBr;
    string req;
  } item_t;

  item_t sbQueue[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  function automatic logic sufModel(input logic [3:0] s, input logic [3:0] f);
    logic c, n, v, z;
    c = f[3]; n = f[2]; v = f[1]; z = f[0];
    case (s)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return !z && (n == v);
      4'd3:  return n != v;
      4'd4:  return n == v;
      4'd5:  return z || (n != v);
      4'd6:  return c;
      4'd7:  return !c;
      4'd8:  return n;
      4'd9:  return !n;
      4'd10: return 1'b1;
      4'd11: return 1'b0;
      4'd12: return v;
      4'd13: return !v;
      4'd14: return c && !z;
      default: return !c || z;
    endcase
  endfunction

  function automatic string sufReq(input logic [3:0] s);
    case (s)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd10, 4'd11: return "R5";
      4'd14, 4'd15: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic drive(input logic a, input logic [4:0] op, input logic [3:0] s, input logic [3:0] f);
    item_t it;
    logic z, n, v;
    z = f[0]; n = f[2]; v = f[1];
    @(posedge clk);
    isAlu <= a; opcode <= op; suffix <= s; flags <= f;
    if (a) begin
      it.expExec = sufModel(s, f); it.expBr = 1'b0;
      it.req = {sufReq(s), "/R8/R9"};
    end else if (op >= 5'd9 && op <= 5'd15) begin
      it.expExec = 1'b1;
      case (op)
        5'd9:  it.expBr = z;
        5'd10: it.expBr = !z;
        5'd11: it.expBr = !z && (v == n);
        5'd12: it.expBr = v == n;
        5'd13: it.expBr = v != n;
        5'd14: it.expBr = z && (v != n);
        default: it.expBr = 1'b1;
      endcase
      it.req = "R6/R7";
    end else if (op == 5'd8) begin
      it.expExec = 1'b1; it.expBr = 1'b0; it.req = "R7/R8";
    end else begin
      it.expExec = sufModel(s, f); it.expBr = 1'b0; it.req = "R9/R8";
    end
    sbQueue.push_back(it);
  endtask

  // Monitor: compares away from the driving edge.
  always @(negedge clk) begin
    if (!rst && sbQueue.size() > 0) begin
      item_t it;
      it = sbQueue.pop_front();
      testsRun++;
      if (execEnable !== it.expExec || branchTaken !== it.expBr) begin
        testsFailed++;
        $display("FAIL %s: exec=%0b br=%0b expected exec=%0b br=%0b (alu=%0b opc=%b suf=%b flags=%b)",
                 it.req, execEnable, branchTaken, it.expExec, it.expBr, isAlu, opcode, suffix, flags);
      end
    end
  end

  initial begin
    isAlu = 1'b0; opcode = 5'd0; suffix = 4'd0; flags = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    // Idle state: load with suffix eq and zero clear must not run (R1, R8).
    testsRun++;
    if (execEnable !== 1'b0 || branchTaken !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1/R8 idle: exec=%0b br=%0b expected exec=0 br=0", execEnable, branchTaken);
    end
    rst = 1'b0;
    // ALU format: every suffix against every flag set, opcode noise (R9).
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        drive(1'b1, 5'(f * 3 + s), 4'(s), 4'(f));
    // Non-ALU: every opcode, every flag set, several suffixes (R6, R7, R8, R9).
    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 16; f++) begin
        drive(1'b0, 5'(op), 4'd0,  4'(f));
        drive(1'b0, 5'(op), 4'd10, 4'(f));
        drive(1'b0, 5'(op), 4'd11, 4'(f));
        drive(1'b0, 5'(op), 4'd15, 4'(f));
      end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule